// File: doc/BRIEF.md
# Two-Channel DMA Controller

This block moves words between memory and peripherals for two independent channels. Software programs each channel through a small register window: a control word, a source address, a destination address, a byte count, a next-address preload, and a sticky status word. Setting the start bit arms the channel. An armed channel waits until its peripheral asks for service, either while its request line is held high or once per rising edge of that line. The controller then requests bus ownership and runs single-beat operations on a simple master port.

In single-address mode one bus operation moves a word. The controller drives only the memory address and selects the peripheral with its acknowledge line. In dual-address mode the controller reads the source into an internal holding register and then writes that word to the destination. The acknowledge line is raised only during the phase that touches the peripheral. When the count reaches zero the channel halts with a normal completion. A bus error halts it with an abnormal completion. In continue mode, a single-address channel reloads its preset next address and its initial count and keeps running. A level interrupt output reports completions for channels whose interrupt enable is set.

Top module: `dma2ch`

## Requirements
- R1: After reset every register reads 0, and `irq`, `bus_req`, `m_valid` and `dack` are all 0.
- R2: Register address bit 3 selects the channel, and bits 2:0 select the register: 0 control, 1 source, 2 destination, 3 count, 4 next address, 5 status. Control bits are: 0 start, 1 edge mode, 2 dual mode, 3 continue, 4 direction, 5 interrupt enable. Status bits are: 0 normal done, 1 error.
- R3: In level mode an armed channel requests service on every transfer unit for as long as its `dreq` bit is 1.
- R4: In edge mode each rising edge of `dreq` records one pending request, and each serviced unit consumes exactly one.
- R5: A single-address unit is one bus operation. It drives the source address with `m_write` equal to the direction bit and `m_wdata` of 0, and holds the channel's `dack` bit at 1. The source then advances by 4.
- R6: A dual-address unit first reads the source (`m_write`=0, `m_wdata`=0) and then writes the read data to the destination. `dack` is 1 during the write phase when direction is 0, and during the read phase when direction is 1. Both addresses advance by 4.
- R7: Each unit lowers the count by 4. A unit started with a count of 4 or less is the last one: it sets done, clears start, and no further operations follow.
- R8: A bus operation answered with `m_err` ends the unit at once. It sets the error bit, clears start, and leaves done unchanged.
- R9: In continue mode, when a single-address channel completes normally, it reloads the source from next address and the count from its last written value. It sets done and stays started.
- R10: When both channels request, channel 0 is served first. Arbitration happens only between units.
- R11: `irq` is the OR over channels of interrupt enable AND (done OR error). Writing 1 to a status bit clears it.
- R12: `bus_req` is 1 while a request is pending or a unit is in progress, and an operation starts only after `bus_gnt`. `m_valid` stays 1, with `m_addr` and `m_write` stable, until `m_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | 2 | Per-channel transfer request, active high |
| dack | output | 2 | Per-channel peripheral acknowledge |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| m_valid | output | 1 | Bus operation valid |
| m_write | output | 1 | Bus operation is a write |
| m_addr | output | 32 | Bus address |
| m_wdata | output | 32 | Bus write data |
| m_ready | input | 1 | Bus operation accepted |
| m_rdata | input | 32 | Bus read data |
| m_err | input | 1 | Bus error response |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds its own queue of expected bus operations and compares every accepted operation against it. Any operation issued after a halt shows up as an unexpected transaction. One stimulus holds a level request high after the last unit: a controller that kept running past a count of zero would emit an extra word. Another stimulus raises both requests together: swapped priority, or arbitration in the middle of a unit, would interleave channel 1 between channel 0's words. Further cases cover an error in the middle of a block, where a failure would leave done set or start still armed, and continue mode, where the bench checks that the source address is reloaded and the channel stays armed across the wrap. Dual-address transfers are run in both directions to catch data that is not carried from the read phase to the write phase, and an acknowledge raised on the wrong phase.

// File: rtl/dma2ch_pkg.sv
package dma2ch_pkg;
  parameter int AW = 32;
  parameter int DW = 32;
  parameter int UNIT_BYTES = 4;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_SRC  = 3'd1;
  localparam logic [2:0] OFS_DST  = 3'd2;
  localparam logic [2:0] OFS_CNT  = 3'd3;
  localparam logic [2:0] OFS_NEXT = 3'd4;
  localparam logic [2:0] OFS_STAT = 3'd5;

  // bit 0 = start ... bit 5 = interrupt enable
  typedef struct packed {
    logic ie;
    logic dir;
    logic cont;
    logic dual;
    logic edge_m;
    logic start;
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_P1, ST_P2} eng_st_t;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + AW'(UNIT_BYTES);
  endfunction

  function automatic logic [DW-1:0] step_count(input logic [DW-1:0] c);
    return (c > DW'(UNIT_BYTES)) ? c - DW'(UNIT_BYTES) : '0;
  endfunction

  function automatic logic is_last(input logic [DW-1:0] c);
    return c <= DW'(UNIT_BYTES);
  endfunction
endpackage

// File: rtl/dma2ch_reqdet.sv
module dma2ch_reqdet (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq,
  input  logic edge_m,
  input  logic service,
  output logic req
);
  logic dreq_q, pend;
  logic rise;

  assign rise = dreq & ~dreq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dreq_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      dreq_q <= dreq;
      pend   <= edge_m ? ((pend & ~service) | rise) : 1'b0;
    end
  end

  assign req = edge_m ? pend : dreq;

  // R4
  edge_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_m && rise) |=> req);
endmodule

// File: rtl/dma2ch_regs.sv
module dma2ch_regs
  import dma2ch_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_ofs,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_ofs,
  output logic [DW-1:0] rd_data,
  input  logic          unit_ok,
  input  logic          unit_err,
  output ctrl_t         ctrl,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic          irq
);
  logic [DW-1:0] cnt, cnt_init;
  logic [AW-1:0] nxt;
  logic done, err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; src <= '0; dst <= '0; cnt <= '0; cnt_init <= '0;
      nxt <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_ofs)
          OFS_CTRL: ctrl <= ctrl_t'(wr_data[5:0]);
          OFS_SRC:  src  <= wr_data;
          OFS_DST:  dst  <= wr_data;
          OFS_CNT:  begin cnt <= wr_data; cnt_init <= wr_data; end
          OFS_NEXT: nxt  <= wr_data;
          OFS_STAT: begin
            done <= done & ~wr_data[0];
            err  <= err & ~wr_data[1];
          end
          default: ;
        endcase
      end
      if (unit_err) begin
        ctrl.start <= 1'b0;
        err        <= 1'b1;
      end else if (unit_ok) begin
        src <= step_addr(src);
        if (ctrl.dual) dst <= step_addr(dst);
        cnt <= step_count(cnt);
        if (is_last(cnt)) begin
          done <= 1'b1;
          if (ctrl.cont && !ctrl.dual) begin
            src <= nxt;
            cnt <= cnt_init;
          end else begin
            ctrl.start <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    case (rd_ofs)
      OFS_CTRL: rd_data = {{(DW-6){1'b0}}, ctrl};
      OFS_SRC:  rd_data = src;
      OFS_DST:  rd_data = dst;
      OFS_CNT:  rd_data = cnt;
      OFS_NEXT: rd_data = nxt;
      OFS_STAT: rd_data = {{(DW-2){1'b0}}, err, done};
      default:  rd_data = '0;
    endcase
  end

  assign irq = ctrl.ie & (done | err);

  // R7
  halted_no_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_ok || unit_err) |-> ctrl.start);
  // R8
  error_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_err |=> (!ctrl.start && err));
  // R9
  continue_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_ok && is_last(cnt) && ctrl.cont && !ctrl.dual && !wr_en) |=> (ctrl.start && src == $past(nxt)));
endmodule

// File: rtl/dma2ch_engine.sv
module dma2ch_engine
  import dma2ch_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] active,
  input  logic [NCH-1:0] dual,
  input  logic [NCH-1:0] dir,
  input  logic [AW-1:0]  src_a [NCH],
  input  logic [AW-1:0]  dst_a [NCH],
  input  logic           bus_gnt,
  output logic           bus_req,
  output logic           m_valid,
  output logic           m_write,
  output logic [AW-1:0]  m_addr,
  output logic [DW-1:0]  m_wdata,
  input  logic           m_ready,
  input  logic [DW-1:0]  m_rdata,
  input  logic           m_err,
  output logic [NCH-1:0] dack,
  output logic [NCH-1:0] unit_ok,
  output logic [NCH-1:0] unit_err
);
  eng_st_t       state;
  logic [CW-1:0] cur, sel;
  logic          found, io_phase, unit_end;
  logic [DW-1:0] hold;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (!found && req[i] && active[i]) begin
        found = 1'b1;
        sel   = CW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cur   <= '0;
      hold  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (found && bus_gnt) begin cur <= sel; state <= ST_P1; end
        ST_P1: if (m_ready) begin
          if (m_err) state <= ST_IDLE;
          else if (dual[cur]) begin hold <= m_rdata; state <= ST_P2; end
          else state <= ST_IDLE;
        end
        ST_P2: if (m_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_req  = found || (state != ST_IDLE);
  assign m_valid  = (state != ST_IDLE);
  assign m_addr   = (state == ST_P2) ? dst_a[cur] : src_a[cur];
  assign m_write  = (state == ST_P2) ? 1'b1 : (dual[cur] ? 1'b0 : dir[cur]);
  assign m_wdata  = (state == ST_P2) ? hold : '0;
  assign io_phase = !dual[cur] || ((state == ST_P2) ? !dir[cur] : dir[cur]);
  assign unit_end = m_valid && m_ready &&
                    (m_err || state == ST_P2 || !dual[cur]);

  always_comb begin
    dack     = '0;
    unit_ok  = '0;
    unit_err = '0;
    dack[cur]     = m_valid && io_phase;
    unit_ok[cur]  = unit_end && !m_err;
    unit_err[cur] = unit_end && m_err;
  end

  // R12
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)));
  // R12
  start_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(bus_gnt));
  // R5
  single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));
  // R10
  low_channel_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && bus_gnt && req[0] && active[0]) |=> (cur == '0));
endmodule

// File: rtl/dma2ch.sv
module dma2ch
  import dma2ch_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RAW = 3 + CW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_waddr,
  input  logic [DW-1:0]  reg_wdata,
  input  logic [RAW-1:0] reg_raddr,
  output logic [DW-1:0]  reg_rdata,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           m_valid,
  output logic           m_write,
  output logic [AW-1:0]  m_addr,
  output logic [DW-1:0]  m_wdata,
  input  logic           m_ready,
  input  logic [DW-1:0]  m_rdata,
  input  logic           m_err,
  output logic           irq
);
  logic [NCH-1:0] req, active, dual, dir, ch_irq, unit_ok, unit_err;
  logic [AW-1:0]  src_a [NCH];
  logic [AW-1:0]  dst_a [NCH];
  logic [DW-1:0]  rd_a  [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ctrl_t ctrl;

    dma2ch_reqdet u_req (
      .clk(clk), .rst_n(rst_n), .dreq(dreq[g]), .edge_m(ctrl.edge_m),
      .service(unit_ok[g] | unit_err[g]), .req(req[g])
    );

    dma2ch_regs u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_we && reg_waddr[RAW-1:3] == CW'(g)),
      .wr_ofs(reg_waddr[2:0]), .wr_data(reg_wdata),
      .rd_ofs(reg_raddr[2:0]), .rd_data(rd_a[g]),
      .unit_ok(unit_ok[g]), .unit_err(unit_err[g]),
      .ctrl(ctrl), .src(src_a[g]), .dst(dst_a[g]), .irq(ch_irq[g])
    );

    assign active[g] = ctrl.start;
    assign dual[g]   = ctrl.dual;
    assign dir[g]    = ctrl.dir;
  end

  dma2ch_engine #(.NCH(NCH)) u_eng (
    .clk(clk), .rst_n(rst_n), .req(req), .active(active), .dual(dual),
    .dir(dir), .src_a(src_a), .dst_a(dst_a), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .m_valid(m_valid), .m_write(m_write),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready),
    .m_rdata(m_rdata), .m_err(m_err), .dack(dack),
    .unit_ok(unit_ok), .unit_err(unit_err)
  );

  assign reg_rdata = rd_a[reg_raddr[RAW-1:3]];
  assign irq       = |ch_irq;

  // R11
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(unit_ok) != '0 || $past(unit_err) != '0 || $past(reg_we)));
endmodule

// File: tb/dma2ch_bench.sv
module dma2ch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  dreq = '0, dack;
  logic        bus_req, bus_gnt = 1'b0;
  logic        m_valid, m_write, m_ready = 1'b0, m_err = 1'b0;
  logic [31:0] m_addr, m_wdata, m_rdata = '0;
  logic        irq;

  int checks = 0, errors = 0;
  logic [31:0] q_addr[$], q_data[$];
  logic        q_wr[$];
  logic [1:0]  q_dack[$];
  string       q_tag[$];

  localparam logic [31:0] ERR_ADDR = 32'h0000_0E00;

  always #5 clk = ~clk;

  dma2ch u_dma2ch (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .dreq(dreq), .dack(dack), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err), .irq(irq)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_op(input string tag, input logic [31:0] a, input logic w,
                           input logic [31:0] d, input logic [1:0] k);
    q_addr.push_back(a); q_wr.push_back(w); q_data.push_back(d);
    q_dack.push_back(k); q_tag.push_back(tag);
  endtask

  // Bus slave: grant follows request, accept each op one cycle after it appears.
  always @(negedge clk) begin
    bus_gnt <= bus_req;
    if (rst_n && m_valid && !m_ready) begin
      if (q_addr.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: unexpected op actual addr %h expected none", m_addr);
      end else begin
        string t;
        t = q_tag.pop_front();
        chk({t, " addr"}, m_addr, q_addr.pop_front());
        chk({t, " write"}, {31'b0, m_write}, {31'b0, q_wr.pop_front()});
        chk({t, " wdata"}, m_wdata, q_data.pop_front());
        chk({t, " dack"}, {30'b0, dack}, {30'b0, q_dack.pop_front()});
      end
      m_ready <= 1'b1;
      m_rdata <= mem_word(m_addr);
      m_err   <= (m_addr == ERR_ADDR);
    end else begin
      m_ready <= 1'b0;
      m_err   <= 1'b0;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    reg_raddr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic drain();
    int n = 0;
    while (q_addr.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (8) @(negedge clk);
    chk("R12 queue drained", q_addr.size(), 0);
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); dreq[ch] = 1'b1;
    @(negedge clk); dreq[ch] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 bus_req", {31'b0, bus_req}, 0);
    chk("R1 m_valid", {31'b0, m_valid}, 0);
    chk("R1 dack", {30'b0, dack}, 0);
    rd_chk("R1 ctrl0", 4'h0, 0);
    rd_chk("R1 cnt1", 4'hB, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R5 R7 level single read, ie=1; request held after the end
    wr(4'h1, 32'h100); wr(4'h3, 12);
    expect_op("R5 u0", 32'h100, 0, 0, 2'b01);
    expect_op("R5 u1", 32'h104, 0, 0, 2'b01);
    expect_op("R3 u2", 32'h108, 0, 0, 2'b01);
    wr(4'h0, 32'h21);
    dreq[0] = 1'b1;
    drain();
    repeat (20) @(negedge clk);
    chk("R7 no op after halt", q_addr.size(), 0);
    dreq[0] = 1'b0;
    rd_chk("R7 status done", 4'h5, 32'h1);
    rd_chk("R7 start cleared", 4'h0, 32'h20);
    rd_chk("R7 count zero", 4'h3, 0);
    rd_chk("R5 src advanced", 4'h1, 32'h10C);
    chk("R11 irq set", {31'b0, irq}, 1);
    wr(4'h5, 32'h1);
    chk("R11 irq cleared", {31'b0, irq}, 0);
    rd_chk("R11 status w1c", 4'h5, 0);

    // R4 R6 edge dual, direction 0 on channel 1 (register base 8), ie=0
    wr(4'h9, 32'h200); wr(4'hA, 32'h300); wr(4'hB, 8);
    wr(4'h8, 32'h07);
    expect_op("R6 rd0", 32'h200, 0, 0, 2'b00);
    expect_op("R6 wr0", 32'h300, 1, mem_word(32'h200), 2'b10);
    pulse(1);
    drain();
    rd_chk("R4 one unit per edge", 4'hB, 4);
    expect_op("R6 rd1", 32'h204, 0, 0, 2'b00);
    expect_op("R6 wr1", 32'h304, 1, mem_word(32'h204), 2'b10);
    pulse(1);
    drain();
    rd_chk("R7 ch1 done", 4'hD, 32'h1);
    rd_chk("R6 dst advanced", 4'hA, 32'h308);
    chk("R11 irq masked", {31'b0, irq}, 0);
    wr(4'hD, 32'h1);

    // R6 dual, direction 1: acknowledge on read phase
    wr(4'h1, 32'h280); wr(4'h2, 32'h380); wr(4'h3, 4);
    wr(4'h0, 32'h15);
    expect_op("R6 dir1 rd", 32'h280, 0, 0, 2'b01);
    expect_op("R6 dir1 wr", 32'h380, 1, mem_word(32'h280), 2'b00);
    dreq[0] = 1'b1;
    drain();
    dreq[0] = 1'b0;
    wr(4'h5, 32'h1);

    // R10 both request together
    wr(4'h1, 32'h400); wr(4'h3, 8); wr(4'h0, 32'h01);
    wr(4'h9, 32'h500); wr(4'hB, 4); wr(4'h8, 32'h11);
    expect_op("R10 ch0 first", 32'h400, 0, 0, 2'b01);
    expect_op("R10 ch0 again", 32'h404, 0, 0, 2'b01);
    expect_op("R10 ch1 last", 32'h500, 1, 0, 2'b10);
    @(negedge clk); dreq = 2'b11;
    drain();
    dreq = 2'b00;
    wr(4'h5, 32'h1); wr(4'hD, 32'h1);

    // R8 error in mid block
    wr(4'h1, 32'hDFC); wr(4'h3, 12); wr(4'h0, 32'h21);
    expect_op("R8 ok unit", 32'hDFC, 0, 0, 2'b01);
    expect_op("R8 err unit", ERR_ADDR, 0, 0, 2'b01);
    dreq[0] = 1'b1;
    drain();
    dreq[0] = 1'b0;
    rd_chk("R8 status err only", 4'h5, 32'h2);
    rd_chk("R8 start cleared", 4'h0, 32'h20);
    chk("R11 irq on error", {31'b0, irq}, 1);
    wr(4'h5, 32'h2);
    chk("R11 irq err cleared", {31'b0, irq}, 0);

    // R9 continue mode, edge requests
    wr(4'h1, 32'h600); wr(4'h4, 32'h700); wr(4'h3, 8); wr(4'h0, 32'h0B);
    expect_op("R9 u0", 32'h600, 0, 0, 2'b01);
    pulse(0); drain();
    expect_op("R9 u1", 32'h604, 0, 0, 2'b01);
    pulse(0); drain();
    rd_chk("R9 done set", 4'h5, 32'h1);
    rd_chk("R9 still started", 4'h0, 32'h0B);
    rd_chk("R9 src reloaded", 4'h1, 32'h700);
    rd_chk("R9 count reloaded", 4'h3, 8);
    expect_op("R9 u2", 32'h700, 0, 0, 2'b01);
    pulse(0); drain();
    expect_op("R9 u3", 32'h704, 0, 0, 2'b01);
    pulse(0); drain();
    wr(4'h0, 0);
    rd_chk("R2 ctrl written", 4'h0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule